// File: doc/BRIEF.md
# Maskable interrupt status controller

The block gathers eight interrupt sources into one latched status byte and drives a single interrupt line from it. Seven sources arrive as one-cycle event pulses. The eighth is a level-sensitive core interrupt, and only its rising edge is latched. Once a status bit is set, it stays set until software clears it.

Software reaches the block through a small register port with three addresses. Address 0 holds the enable mask. Address 1 is the status view: writing ones to it injects interrupts, and bit 31 of a read shows the raw core level. Address 2 is a write-one-to-clear register. The interrupt output is high whenever a latched status bit is also enabled in the mask.

The status bit positions are fixed:

| Bit | Source |
|-----|--------|
| 0 | Core rising edge |
| 1 | Hot-plug rise |
| 2 | Hot-plug fall |
| 3 | Nonce-refresh rise |
| 4 | Random-number error |
| 5 | I2C timeout |
| 6 | Receiver-sense rise |
| 7 | Receiver-sense fall |

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask and all status bits are 0, so `irq_o` is 0.
- R2: A write to address 0 loads the mask from `reg_wdata[7:0]`. A read of address 0 returns the mask in bits 7:0 and zeros in all other bits.
- R3: A pulse on `src_evt[n]` (n from 1 to 7) sets status bit n at the next clock edge. The bit then stays set until it is cleared.
- R4: Status bit 0 is set by a rising edge of `core_irq`. Keeping `core_irq` high after that bit has been cleared does not set it again.
- R5: A read of address 1 returns the status in bits 7:0 and the present `core_irq` level in bit 31.
- R6: A write to address 1 sets every status bit whose `reg_wdata` bit is 1. Status bits written with 0 keep their value.
- R7: A write to address 2 clears every status bit whose `reg_wdata` bit is 1. Status bits written with 0 keep their value.
- R8: If a hardware set and a clear write reach the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address: 0 mask, 1 status, 2 clear |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| core_irq | input | 1 | Raw core interrupt level |
| src_evt | input | 7 | Event pulses for status bits 7:1 |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that every event pulse and register write is sampled at a clock edge, and that the register port presents only one address per cycle. Because of that, a software set and a software clear never reach the same bit in the same cycle. The stimulus drives every input on the falling clock edge and never mixes two register operations in one cycle. It also changes `core_irq` only between vectors, so each edge of the core level can be placed on purpose, including one held high across a clear.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NSRC = 8,
  parameter int AW   = 2,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          core_irq,
  input  logic [NSRC-1:1] src_evt,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);

  logic            core_d;
  logic [NSRC-1:0] mask_q, stat_q, hw_set, sw_set, sw_clr;

  assign hw_set = {src_evt, core_irq & ~core_d};
  assign sw_set = (reg_we && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;
  assign sw_clr = (reg_we && reg_addr == A_CLR)  ? reg_wdata[NSRC-1:0] : '0;
  assign irq_o  = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_d <= 1'b0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      core_d <= core_irq;
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[NSRC-1:0];
      stat_q <= (stat_q & ~sw_clr) | sw_set | hw_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK: reg_rdata[NSRC-1:0] = mask_q;
      A_STAT: begin
        reg_rdata[NSRC-1:0] = stat_q;
        reg_rdata[DW-1]     = core_irq;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int NSRC = 8,
  parameter int AW   = 2,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_we,
  input logic [DW-1:0]   reg_wdata,
  input logic            core_irq,
  input logic [NSRC-1:1] src_evt,
  input logic [NSRC-1:0] stat,
  input logic [NSRC-1:0] mask,
  input logic            irq_o
);
  // R9
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
  // R9
  stat_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !irq_o);
  // R3 R8
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((stat & $past({src_evt, 1'b0})) == $past({src_evt, 1'b0})));
  // R4
  core_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_irq) |=> stat[0]);
  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(1)) |=>
      ((stat & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));
  // R7
  sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(2)) |=>
      ((stat & $past(reg_wdata[NSRC-1:0] & ~{src_evt, 1'b1})) == '0));
endmodule

bind irq_status_ctrl irq_status_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_irq_status_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .core_irq(core_irq), .src_evt(src_evt),
  .stat(stat_q), .mask(mask_q), .irq_o(irq_o));

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_irq = 1'b0;
  logic [7:1]  src_evt = '0;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
    .src_evt(src_evt), .irq_o(irq_o));

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [7:0]  wd;
    logic [7:1]  evt;
    logic        core;
    logic [31:0] exp_stat;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 8'hFF, 7'h00, 1'b0, 32'h0000_0000, 1'b0, 4'd2}, // R2 enable all
    '{1'b0, 2'd1, 8'h00, 7'h01, 1'b0, 32'h0000_0002, 1'b1, 4'd3}, // R3 hot-plug rise
    '{1'b1, 2'd1, 8'h30, 7'h00, 1'b0, 32'h0000_0032, 1'b1, 4'd6}, // R6 inject
    '{1'b1, 2'd2, 8'h02, 7'h00, 1'b0, 32'h0000_0030, 1'b1, 4'd7}, // R7 clear one
    '{1'b0, 2'd1, 8'h00, 7'h00, 1'b1, 32'h8000_0031, 1'b1, 4'd4}, // R4 R5 core rise
    '{1'b1, 2'd2, 8'h01, 7'h00, 1'b1, 32'h8000_0030, 1'b1, 4'd4}, // R4 held high, no reset
    '{1'b0, 2'd1, 8'h00, 7'h00, 1'b0, 32'h0000_0030, 1'b1, 4'd5}, // R5 core low
    '{1'b1, 2'd2, 8'h30, 7'h10, 1'b0, 32'h0000_0020, 1'b1, 4'd8}, // R8 set beats clear
    '{1'b1, 2'd0, 8'h01, 7'h00, 1'b0, 32'h0000_0020, 1'b0, 4'd9}, // R9 masked off
    '{1'b1, 2'd1, 8'h00, 7'h00, 1'b0, 32'h0000_0020, 1'b0, 4'd6}, // R6 zero write
    '{1'b1, 2'd2, 8'h00, 7'h00, 1'b0, 32'h0000_0020, 1'b0, 4'd7}, // R7 zero write
    '{1'b0, 2'd1, 8'h00, 7'h40, 1'b0, 32'h0000_00A0, 1'b0, 4'd3}  // R3 rx-sense fall
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_read(input logic [1:0] a);
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0; reg_addr = a;
    #1;
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_read(2'd1);
    check("R1 status", reg_rdata, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    reg_addr = 2'd0; #1;
    check("R1 mask", reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_we = VEC[i].we; reg_addr = VEC[i].addr;
      reg_wdata = {24'h00FFFF, VEC[i].wd};
      src_evt = VEC[i].evt; core_irq = VEC[i].core;
      idle_read(2'd1);
      check($sformatf("R%0d vec%0d status", VEC[i].req, i), reg_rdata, VEC[i].exp_stat);
      check($sformatf("R9 vec%0d irq", i), {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
    end

    // R2 readback, upper bits zero despite wide write data
    idle_read(2'd0);
    check("R2 mask readback", reg_rdata, 32'h0000_0001);

    // R9 enable a latched bit again
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h80;
    idle_read(2'd1);
    check("R9 irq re-enabled", {31'b0, irq_o}, 32'h1);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 status after reset", reg_rdata, 32'h0);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule